// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block decides which hardware thread owns the single issue slot of an in-order pipeline that runs switch-on-event multithreading. Each thread has its own program counter register and a ready/stalled flag. The thread that holds the slot issues one instruction every cycle. It keeps the slot until the pipeline reports a long-latency event for it, such as a load that missed in every cache level. The controller then marks that thread stalled and spends exactly one cycle without issue. In the following cycle it hands the slot to the next ready thread in rotation.

A stalled thread becomes a candidate again only when the memory side reports that its data has returned. Because every thread keeps its own PC, a switch only changes which PC register drives the issue port. Nothing is saved or restored. The issue port is a plain valid signal with a thread number and a PC, and it has no back-pressure: a high `issue_valid` means the instruction at `issue_pc` is issued in that cycle. The two event inputs are single-cycle pulses that are always accepted.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset the controller issues from thread 0 at once, with `issue_valid` high, and every thread is ready.
- R10: Each thread t starts at PC `PC_BASE + t*PC_STRIDE`. The first issue from thread t shows that value.
- R2: While no stall is taken, the same thread issues in every cycle and its PC rises by `PC_STEP` (default 4) per issued instruction.
- R3: A stall is taken when `stall_valid` is high, `issue_valid` is high and `stall_tid` equals `issue_tid`. In the cycle after that, `issue_valid` is low. This is the switch bubble.
- R4: After the bubble cycle, issue resumes with the first ready thread found by searching from the stalled thread plus one upward, wrapping modulo the thread count.
- R5: A stalled thread keeps as its PC the address after the instruction that stalled. It resumes issue from exactly that PC.
- R6: A stalled thread is never chosen until a return event names it. A return that arrives in a selection cycle already counts for that selection.
- R7: When no thread is ready, `issue_valid` stays low. If a return arrives in cycle c, the returning thread issues in cycle c+1.
- R8: A stall event is ignored when its thread number differs from `issue_tid` or when `issue_valid` is low. Issue then carries on as if there had been no event.
- R9: A return event for a thread that is already ready has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_valid | input | 1 | Long-latency event pulse |
| stall_tid | input | TID_W | Thread the event belongs to |
| ret_valid | input | 1 | Data-return pulse |
| ret_tid | input | TID_W | Thread whose data came back |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Thread owning the issue slot |
| issue_pc | output | PC_W | PC of the issuing instruction |

## Verification
All outputs come from registers, so an event sampled at a rising edge shows up in the very next cycle. After a taken stall, `issue_valid` drops one cycle later and the new thread appears one cycle after that. A return seen during a selection cycle makes its thread issue in the next cycle. The bench drives inputs and compares outputs at the falling edge, against a model that advances once per rising edge, so each comparison sees exactly the result of the previous edge.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  // ISSUE: the active thread owns the slot; SELECT: bubble or idle, searching
  typedef enum logic {SW_ISSUE = 1'b0, SW_SELECT = 1'b1} sw_state_e;
endpackage

// File: rtl/cgmt_rr_pick.sv
module cgmt_rr_pick #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic [TW-1:0] base,
  output logic          found,
  output logic [TW-1:0] pick
);
  // search base+1 .. base+N (mod N); base itself is examined last
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(base) + k) % N;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/cgmt_ready_track.sv
module cgmt_ready_track #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [TW-1:0] clr_tid,
  input  logic          set_en,
  input  logic [TW-1:0] set_tid,
  output logic [N-1:0]  ready_q,
  output logic [N-1:0]  set_hot
);
  for (genvar t = 0; t < N; t++) begin : g_thr
    logic rdy_r;
    logic clr_hit;
    assign clr_hit    = clr_en && (clr_tid == TW'(t));
    assign set_hot[t] = set_en && (set_tid == TW'(t));
    // a stall has priority over a return naming the same thread
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rdy_r <= 1'b1;
      else if (clr_hit)    rdy_r <= 1'b0;
      else if (set_hot[t]) rdy_r <= 1'b1;
    end
    assign ready_q[t] = rdy_r;
  end
endmodule

// File: rtl/cgmt_pc_bank.sv
module cgmt_pc_bank #(
  parameter int             N         = 4,
  parameter int             TW        = 2,
  parameter int             PC_W      = 32,
  parameter int             PC_STEP   = 4,
  parameter logic [PC_W-1:0] PC_BASE   = '0,
  parameter logic [PC_W-1:0] PC_STRIDE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [TW-1:0]   sel_tid,
  output logic [PC_W-1:0] sel_pc
);
  logic [PC_W-1:0] pc_arr [N];

  for (genvar t = 0; t < N; t++) begin : g_pc
    logic [PC_W-1:0] pc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc_r <= PC_BASE + PC_STRIDE * PC_W'(t);
      else if (adv && (sel_tid == TW'(t)))
        pc_r <= pc_r + PC_W'(PC_STEP);
    end
    assign pc_arr[t] = pc_r;
  end

  assign sel_pc = pc_arr[sel_tid];
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
  import cgmt_pkg::*;
#(
  parameter int              NUM_THREADS = 4,
  parameter int              PC_W        = 32,
  parameter int              PC_STEP     = 4,
  parameter logic [PC_W-1:0] PC_BASE     = 32'h0000_1000,
  parameter logic [PC_W-1:0] PC_STRIDE   = 32'h0001_0000,
  localparam int             TID_W       = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_valid,
  input  logic [TID_W-1:0] stall_tid,
  input  logic             ret_valid,
  input  logic [TID_W-1:0] ret_tid,
  output logic             issue_valid,
  output logic [TID_W-1:0] issue_tid,
  output logic [PC_W-1:0]  issue_pc
);
  sw_state_e              state_q;
  logic [TID_W-1:0]       act_q;
  logic [TID_W-1:0]       base_q;
  logic                   stall_take;
  logic [NUM_THREADS-1:0] ready_q;
  logic [NUM_THREADS-1:0] ret_hot;
  logic                   pick_found;
  logic [TID_W-1:0]       pick_tid;

  assign issue_valid = (state_q == SW_ISSUE);
  assign issue_tid   = act_q;
  assign stall_take  = issue_valid && stall_valid && (stall_tid == act_q);

  cgmt_ready_track #(.N(NUM_THREADS), .TW(TID_W)) u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (stall_take),
    .clr_tid (act_q),
    .set_en  (ret_valid),
    .set_tid (ret_tid),
    .ready_q (ready_q),
    .set_hot (ret_hot)
  );

  // a return in the selection cycle already makes its thread a candidate
  cgmt_rr_pick #(.N(NUM_THREADS), .TW(TID_W)) u_pick (
    .cand  (ready_q | ret_hot),
    .base  (base_q),
    .found (pick_found),
    .pick  (pick_tid)
  );

  cgmt_pc_bank #(
    .N(NUM_THREADS), .TW(TID_W), .PC_W(PC_W), .PC_STEP(PC_STEP),
    .PC_BASE(PC_BASE), .PC_STRIDE(PC_STRIDE)
  ) u_pcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (issue_valid),
    .sel_tid (act_q),
    .sel_pc  (issue_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_ISSUE;
      act_q   <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        SW_ISSUE: begin
          if (stall_take) begin
            state_q <= SW_SELECT;
            base_q  <= act_q;
          end
        end
        default: begin
          if (pick_found) begin
            state_q <= SW_ISSUE;
            act_q   <= pick_tid;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cgmt_switch_chk.sv
module cgmt_switch_chk #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  localparam int TW         = $clog2(NUM_THREADS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall_valid,
  input logic [TW-1:0]   stall_tid,
  input logic            ret_valid,
  input logic [TW-1:0]   ret_tid,
  input logic            issue_valid,
  input logic [TW-1:0]   issue_tid,
  input logic [PC_W-1:0] issue_pc
);
  logic                   took;
  logic [NUM_THREADS-1:0] pend;

  assign took = issue_valid && stall_valid && (stall_tid == issue_tid);

  // threads waiting for data, as seen from the port events alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (took && issue_tid == TW'(t))         pend[t] <= 1'b1;
        else if (ret_valid && ret_tid == TW'(t)) pend[t] <= 1'b0;
      end
    end
  end

  // R3
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> !issue_valid);

  // R2
  same_thread_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !stall_valid) |=>
      (issue_valid && $stable(issue_tid) && issue_pc == $past(issue_pc) + PC_W'(PC_STEP)));

  // R8
  foreign_stall_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && stall_valid && stall_tid != issue_tid) |=> issue_valid);

  // R6
  stalled_never_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !pend[issue_tid]);

  // R7
  all_waiting_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&pend) |-> !issue_valid);
endmodule

bind cgmt_switch_ctrl cgmt_switch_chk #(
  .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .PC_STEP(PC_STEP)
) u_chk (.*);

// File: tb/tb_cgmt_switch_ctrl.sv
`timescale 1ns/1ps
module tb_cgmt_switch_ctrl;
  localparam int          N      = 4;
  localparam int          TW     = 2;
  localparam logic [31:0] BASE   = 32'h0000_1000;
  localparam logic [31:0] STRIDE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic stall_valid = 0, ret_valid = 0;
  logic [TW-1:0] stall_tid = '0, ret_tid = '0;
  logic issue_valid;
  logic [TW-1:0] issue_tid;
  logic [31:0] issue_pc;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit          m_run;
  int          m_act, m_base;
  logic [31:0] m_pc [N];
  bit          m_rdy [N];
  bit          m_seen [N];
  string       m_tag;

  always #4 clk = ~clk;

  cgmt_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stall_valid(stall_valid), .stall_tid(stall_tid),
    .ret_valid(ret_valid), .ret_tid(ret_tid), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(issue_valid === m_run, m_tag, "issue_valid", longint'(issue_valid), longint'(m_run));
    if (m_run) begin
      chk(int'(issue_tid) == m_act, m_tag, "issue_tid", longint'(issue_tid), longint'(m_act));
      chk(issue_pc === m_pc[m_act], m_tag, "issue_pc", longint'(issue_pc), longint'(m_pc[m_act]));
    end
  endtask

  task automatic model_step(input bit sv, input int st, input bit rv, input int rt);
    bit acc;
    int old;
    acc = m_run && sv && (st == m_act);
    old = m_act;
    if (m_run) begin
      m_seen[m_act] = 1;
      m_pc[m_act]   = m_pc[m_act] + 32'd4;
      if (acc) begin
        m_rdy[m_act] = 0; m_base = m_act; m_run = 0; m_tag = "R3";
      end else if (sv) m_tag = "R8";
      else if (rv && m_rdy[rt]) m_tag = "R9";
      else m_tag = "R2";
    end else begin
      m_tag = sv ? "R8/R7" : "R7";
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (m_base + k) % N;
        if (!m_run && (m_rdy[idx] || (rv && rt == idx))) begin
          m_run = 1; m_act = idx;
          m_tag = m_seen[idx] ? "R4/R5/R6" : "R4/R10";
        end
      end
    end
    if (rv && !(acc && rt == old)) m_rdy[rt] = 1;
  endtask

  // compare current outputs, drive one cycle of inputs, advance model
  task automatic cyc(input bit sv, input int st, input bit rv, input int rt);
    compare();
    stall_valid = sv; stall_tid = TW'(st);
    ret_valid   = rv; ret_tid   = TW'(rt);
    model_step(sv, st, rv, rt);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_run = 1; m_act = 0; m_base = 0; m_tag = "R1/R10";
    for (int t = 0; t < N; t++) begin
      m_pc[t] = BASE + STRIDE * t; m_rdy[t] = 1; m_seen[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state and R2 plain run
    repeat (3) cyc(0, 0, 0, 0);
    // R8 stall naming a different thread
    cyc(1, 2, 0, 0);
    cyc(0, 0, 0, 0);
    // R9 return for a ready thread
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    // R3/R4/R10 stall every thread in turn until all wait
    for (int t = 0; t < N; t++) begin
      cyc(1, t, 0, 0);   // stall taken
      cyc(0, 0, 0, 0);   // bubble
      cyc(0, 0, 0, 0);   // new thread (or idle after last)
    end
    // R7 idle with every thread waiting; stall while idle is ignored (R8)
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    // R7 return in cycle c -> issue in c+1; R5 resume PC
    cyc(0, 0, 1, 2);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    // R6 return arriving during the bubble is used at once
    cyc(1, 2, 0, 0);
    cyc(0, 0, 1, 3);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 2);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit sv, rv;
      int st, rt;
      sv = ($urandom % 6) == 0;
      st = (($urandom % 5) == 0) ? int'($urandom % N) : int'(issue_tid);
      rv = ($urandom % 4) == 0;
      rt = int'($urandom % N);
      cyc(sv, st, rv, rt);
    end
    compare();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule